// File: doc/BRIEF.md
# Clock Generator Control Register Slave

A two-wire serial slave that gives a host access to a bank of four eight-bit control registers for a clock generator. The host's clock and data lines are oversampled by the system clock. The slave pulls the data line low through an output-enable, in open-drain style. It recognises one fixed seven-bit bus address. After the address, a command byte tells it whether the transfer works on a single indexed register or on the whole bank in ascending order. Only a chip-select field of zero in that byte lets the transfer go ahead.

The register contents drive a set of plain control ports: one enable per clock output, a spread-spectrum enable, a spread-depth select and an output-frequency select. Four transfer types are supported: single-register write, single-register read, bank write and bank read. A read repeats the start condition and sends the address again with the read bit set. A bank transfer carries a byte-count byte ahead of the data. Writes land in the registers as each byte completes, so a transfer may stop after any whole byte.

Top module: `ckc_ctrl_slave`

## Requirements
- R1: Only the address byte D2h (7-bit address 69h with read/write bit 0) or D3h (read bit 1) is acknowledged. Any other address byte gets no acknowledge, and the rest of that transfer, up to the next start, is left unacknowledged and has no effect.
- R2: Command bit 7 = 1 selects single-register mode with the offset in bits 4:0. Bit 7 = 0 selects bank mode, which always begins at register 0 whatever bits 4:0 hold.
- R3: A command byte whose bits 6:5 are not 00 is not acknowledged, and nothing in that transfer is written.
- R4: A single-register write to an offset of 4 or more is acknowledged but changes nothing. A single-register read at such an offset returns 00h.
- R5: A single-register read (address+W, command, repeated start, D3h) returns the addressed register, most significant bit first.
- R6: In a bank write (address+W, command, count byte, data), every byte is acknowledged. Data bytes fill registers 0,1,2,3 in order, whatever the count value says, and bytes past register 3 are discarded.
- R7: A bank read returns 04h first, then registers 0 to 3 in ascending order, then 00h for any further byte the master acknowledges. The slave stops driving after the master's not-acknowledge.
- R8: A start or stop in the middle of a byte abandons the transfer. The partial byte writes nothing, and a new transfer that follows at once behaves normally.
- R9: After reset, register 0 = 0Fh, register 1 = 00h, register 2 = 07h and register 3 = AFh.
- R10: Register 0 bits 3:0 drive out_en_o[3:0], where 1 enables the output and 0 sets it to high impedance. Register 2 bit 0 drives freq_sel_o (1 = 200 MHz, 0 = 100 MHz). Register 2 bit 1 drives spread_en_o. Register 2 bit 2 drives spread_wide_o (1 = -0.5%, 0 = -0.35%). These ports change only after a register write.
- R11: The slave changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| out_en_o | output | 4 | Per-output enable, 1 = driving |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_wide_o | output | 1 | Spread depth, 1 = -0.5%, 0 = -0.35% |
| freq_sel_o | output | 1 | Output frequency, 1 = 200 MHz, 0 = 100 MHz |

## Verification
The bench targets these corner cases:
- A bank write with a count of five. A design that let the count or the fifth byte reach the bank would corrupt register 0 or hang without an acknowledge.
- A bank command whose offset bits are nonzero. A design that honoured those bits would return the wrong first register.
- Reads that run past register 3, and single-register access at offset 9. A design that wrapped its pointer would return or overwrite live registers instead of 00h and no change.
- Transfers cut short by a start or a stop halfway through a byte, and address or chip-select bytes that should be refused. A design that committed partial bytes, or acknowledged foreign traffic, would alter the control ports that the bench checks afterwards.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

    localparam int OFS_W       = 5;
    localparam int FREQ_BIT    = 0;
    localparam int SPR_EN_BIT  = 1;
    localparam int SPR_WID_BIT = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        P_ADDR,
        P_CMD,
        P_CNT,
        P_DATA
    } phase_e;

    typedef struct packed {
        bus_st_e          st;
        phase_e           ph;
        logic [3:0]       bitcnt;
        logic [7:0]       sh;
        logic             rd;
        logic             blk;
        logic             hdr;
        logic [OFS_W-1:0] ptr;
        logic             ack;
        logic             oe;
    } ctl_s;

    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } evt_s;

endpackage

// File: rtl/ckc_sync.sv
module ckc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        if (s == 0) begin : g_first
            assign stg_d[s] = din;
        end else begin : g_next
            assign stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ckc_bus_events.sv
module ckc_bus_events
    import ckc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);

    logic [1:0] synced;
    evt_s       ev_d, ev_q;

    ckc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_raw, sda_raw}),
        .dout (synced)
    );

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    always_comb begin
        ev_d.scl_p = scl_s;
        ev_d.sda_p = sda_s;
        start_ev   = scl_s && ev_q.scl_p && ev_q.sda_p && !sda_s;
        stop_ev    = scl_s && ev_q.scl_p && !ev_q.sda_p && sda_s;
        scl_rise   = scl_s && !ev_q.scl_p;
        scl_fall   = !scl_s && ev_q.scl_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        else        ev_q <= ev_d;
    end

endmodule

// File: rtl/ckc_regfile.sv
module ckc_regfile #(
    parameter int                NREG    = 4,
    parameter logic [NREG*8-1:0] RST_VAL = '0,
    localparam int               IDXW    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [IDXW-1:0]   rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_o
);

    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = (wr_en && wr_idx == IDXW'(i)) ? wr_data : regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= RST_VAL[i*8 +: 8];
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_data = regs_q[rd_idx];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_o[i*8 +: 8] = regs_q[i];
    end

endmodule

// File: rtl/ckc_ctrl_slave.sv
module ckc_ctrl_slave
    import ckc_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h69,
    parameter int         NREG        = 4,
    parameter int         NOUT        = 4,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDXW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    output logic [NOUT-1:0] out_en_o,
    output logic            spread_en_o,
    output logic            spread_wide_o,
    output logic            freq_sel_o
);

    localparam logic [NREG*8-1:0] RST_VAL  = {8'hAF, 8'h07, 8'h00, 8'h0F};
    localparam logic [OFS_W-1:0]  NREG_L   = OFS_W'(NREG);
    localparam logic [7:0]        CNT_BYTE = 8'(NREG);

    logic scl_s, sda_s, start_ev, stop_ev, scl_rise, scl_fall;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;
    logic [7:0]        tx_byte;
    logic [7:0]        nb;
    logic [NREG*8-1:0] regs;
    ctl_s              d, q;

    ckc_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    ckc_regfile #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (q.ptr[IDXW-1:0]),
        .wr_data(wr_data),
        .rd_idx (q.ptr[IDXW-1:0]),
        .rd_data(rd_data),
        .regs_o (regs)
    );

    // byte offered to the master when a transmit byte is loaded
    always_comb begin
        if (q.blk && q.hdr)     tx_byte = CNT_BYTE;
        else if (q.ptr < NREG_L) tx_byte = rd_data;
        else                    tx_byte = 8'h00;
    end

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        nb      = {q.sh[6:0], sda_s};
        wr_data = nb;
        if (stop_ev) begin
            d.st     = S_IDLE;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else if (start_ev) begin
            d.st     = S_RX;
            d.ph     = P_ADDR;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else begin
            unique case (q.st)
                S_RX: begin
                    if (scl_rise && q.bitcnt < 4'd8) begin
                        d.sh     = nb;
                        d.bitcnt = q.bitcnt + 4'd1;
                        if (q.bitcnt == 4'd7) begin
                            unique case (q.ph)
                                P_ADDR: begin
                                    d.ack = (nb[7:1] == SLV_ADDR);
                                    d.rd  = nb[0];
                                end
                                P_CMD: begin
                                    d.ack = (nb[6:5] == 2'b00);
                                    if (nb[6:5] == 2'b00) begin
                                        d.blk = ~nb[7];
                                        d.hdr = ~nb[7];
                                        d.ptr = nb[7] ? nb[OFS_W-1:0] : '0;
                                        d.ph  = nb[7] ? P_DATA : P_CNT;
                                    end
                                end
                                P_CNT: begin
                                    d.ack = 1'b1;
                                    d.hdr = 1'b0;
                                    d.ph  = P_DATA;
                                end
                                P_DATA: begin
                                    d.ack = 1'b1;
                                    if (q.ptr < NREG_L) begin
                                        wr_en = 1'b1;
                                        d.ptr = q.ptr + OFS_W'(1);
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        if (q.ack) begin
                            d.st = S_ACK;
                            d.oe = 1'b1;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        if (q.ph == P_ADDR && q.rd) begin
                            d.st = S_TX;
                            d.sh = tx_byte;
                            d.oe = ~tx_byte[7];
                            if (q.blk && q.hdr)      d.hdr = 1'b0;
                            else if (q.ptr < NREG_L) d.ptr = q.ptr + OFS_W'(1);
                        end else begin
                            d.st = S_RX;
                            if (q.ph == P_ADDR) d.ph = P_CMD;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.st = S_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.oe     = ~q.sh[6];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        d.ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.ack) begin
                            d.st     = S_TX;
                            d.bitcnt = '0;
                            d.sh     = tx_byte;
                            d.oe     = ~tx_byte[7];
                            if (q.blk && q.hdr)      d.hdr = 1'b0;
                            else if (q.ptr < NREG_L) d.ptr = q.ptr + OFS_W'(1);
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, ph: P_ADDR, bitcnt: '0, sh: '0, rd: 1'b0,
                   blk: 1'b0, hdr: 1'b0, ptr: '0, ack: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o      = q.oe;
    assign out_en_o      = regs[NOUT-1:0];
    assign freq_sel_o    = regs[2*8 + FREQ_BIT];
    assign spread_en_o   = regs[2*8 + SPR_EN_BIT];
    assign spread_wide_o = regs[2*8 + SPR_WID_BIT];

endmodule

// File: rtl/ckc_ctrl_slave_chk.sv
module ckc_ctrl_slave_chk #(
    parameter int NOUT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_s,
    input logic            stop_ev,
    input logic            wr_en,
    input logic            sda_oe_o,
    input logic [NOUT-1:0] out_en_o,
    input logic            freq_sel_o,
    input logic            spread_en_o
);

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o); // R8

    AST_DRIVE_BEGINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R11

    AST_DRIVE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o)); // R11

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(out_en_o) && $stable(freq_sel_o) && $stable(spread_en_o))); // R10

    AST_WRITE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> scl_s); // R6

endmodule

bind ckc_ctrl_slave ckc_ctrl_slave_chk #(.NOUT(NOUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_ev    (stop_ev),
    .wr_en      (wr_en),
    .sda_oe_o   (sda_oe_o),
    .out_en_o   (out_en_o),
    .freq_sel_o (freq_sel_o),
    .spread_en_o(spread_en_o)
);

// File: tb/ckc_ctrl_slave_bench.sv
module ckc_ctrl_slave_bench;

    localparam int HP = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic [3:0] out_en;
    logic       spread_en, spread_wide, freq_sel;
    wire        sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    ckc_ctrl_slave u_ckc_ctrl_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .out_en_o     (out_en),
        .spread_en_o  (spread_en),
        .spread_wide_o(spread_wide),
        .freq_sel_o   (freq_sel)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] exp_q [$];
    string      req_q [$];
    logic [7:0] obs_v;
    event       obs_ev;
    logic [7:0] mdl [4];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    task automatic observe(input logic [7:0] v);
        obs_v = v;
        -> obs_ev;
        tick(1);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected item got %02h expected none", obs_v);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      r = req_q.pop_front();
                if (obs_v !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", r, obs_v, e);
                end
            end
        end
    end

    task automatic check_val(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_ports(input string req);
        check_val({req, " out_en"}, {4'h0, out_en}, {4'h0, mdl[0][3:0]});
        check_val({req, " ctrl"}, {5'h0, spread_wide, spread_en, freq_sel},
                  {5'h0, mdl[2][2:0]});
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(HP);
        m_scl = 1'b1; tick(HP);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP / 2);
        b = sda_line; tick(HP / 2);
        m_scl = 1'b0; tick(2);
    endtask

    // send a byte; ack_exp = 1 means the slave must acknowledge (line low)
    task automatic put_byte(input logic [7:0] v, input logic ack_exp, input string req);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        push_exp({7'h0, ~ack_exp}, req);
        observe({7'h0, a});
    endtask

    task automatic get_byte(input logic [7:0] exp, input logic give_ack, input string req);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        push_exp(exp, req);
        observe(v);
        send_bit(~give_ack);
    endtask

    task automatic byte_write(input logic [4:0] ofs, input logic [7:0] val, input string req);
        bus_start();
        put_byte(8'hD2, 1'b1, req);
        put_byte({3'b100, ofs}, 1'b1, req);
        put_byte(val, 1'b1, req);
        bus_stop();
        if (ofs < 5'd4) mdl[ofs[1:0]] = val;
    endtask

    task automatic byte_read(input logic [4:0] ofs, input string req);
        bus_start();
        put_byte(8'hD2, 1'b1, req);
        put_byte({3'b100, ofs}, 1'b1, req);
        bus_start();
        put_byte(8'hD3, 1'b1, req);
        get_byte((ofs < 5'd4) ? mdl[ofs[1:0]] : 8'h00, 1'b0, req);
        bus_stop();
    endtask

    task automatic block_read(input logic [7:0] cmd, input int nbytes, input string req);
        bus_start();
        put_byte(8'hD2, 1'b1, req);
        put_byte(cmd, 1'b1, req);
        bus_start();
        put_byte(8'hD3, 1'b1, req);
        for (int i = 0; i < nbytes; i++) begin
            automatic logic [7:0] e = (i == 0) ? 8'h04 : ((i <= 4) ? mdl[i-1] : 8'h00);
            get_byte(e, (i != nbytes - 1), req);
        end
        bus_stop();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        mdl[0] = 8'h0F; mdl[1] = 8'h00; mdl[2] = 8'h07; mdl[3] = 8'hAF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R9 reset values on the ports and through a bank read
        check_ports("R9");
        check_val("R9 idle drive", {7'h0, sda_oe}, 8'h00);
        block_read(8'h00, 5, "R9");

        // R10 port mapping after single-register writes
        byte_write(5'd2, 8'h02, "R10");
        check_ports("R10");
        byte_write(5'd0, 8'h05, "R10");
        check_ports("R10");

        // R5 single-register reads
        byte_read(5'd2, "R5");
        byte_read(5'd3, "R5");

        // R1 foreign address: nothing acknowledged, nothing written
        bus_start();
        put_byte(8'hA4, 1'b0, "R1");
        put_byte(8'h80, 1'b0, "R1");
        put_byte(8'h00, 1'b0, "R1");
        bus_stop();
        check_ports("R1");

        // R3 nonzero chip-select field
        bus_start();
        put_byte(8'hD2, 1'b1, "R3");
        put_byte(8'hA2, 1'b0, "R3");
        put_byte(8'h00, 1'b0, "R3");
        bus_stop();
        check_ports("R3");

        // R4 out-of-range offset
        byte_write(5'd9, 8'hFF, "R4");
        check_ports("R4");
        byte_read(5'd9, "R4");

        // R6 bank write with five data bytes, fifth discarded
        bus_start();
        put_byte(8'hD2, 1'b1, "R6");
        put_byte(8'h00, 1'b1, "R6");
        put_byte(8'h05, 1'b1, "R6");
        put_byte(8'h0A, 1'b1, "R6");
        put_byte(8'h3C, 1'b1, "R6");
        put_byte(8'h06, 1'b1, "R6");
        put_byte(8'h99, 1'b1, "R6");
        put_byte(8'hEE, 1'b1, "R6");
        bus_stop();
        mdl[0] = 8'h0A; mdl[1] = 8'h3C; mdl[2] = 8'h06; mdl[3] = 8'h99;
        check_ports("R6");

        // R7 bank read running past the bank
        block_read(8'h00, 7, "R7");

        // R6 bank write ended early after two data bytes
        bus_start();
        put_byte(8'hD2, 1'b1, "R6");
        put_byte(8'h00, 1'b1, "R6");
        put_byte(8'h04, 1'b1, "R6");
        put_byte(8'h03, 1'b1, "R6");
        put_byte(8'h44, 1'b1, "R6");
        bus_stop();
        mdl[0] = 8'h03; mdl[1] = 8'h44;
        check_ports("R6");

        // R2 bank command with nonzero offset bits still starts at register 0
        block_read(8'h05, 2, "R2");
        byte_read(5'd1, "R2");

        // R8 repeated start in the middle of a data byte
        bus_start();
        put_byte(8'hD2, 1'b1, "R8");
        put_byte(8'h80, 1'b1, "R8");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_start();
        put_byte(8'hD3, 1'b1, "R8");
        get_byte(mdl[0], 1'b0, "R8");
        bus_stop();
        check_ports("R8");

        // R8 stop in the middle of a data byte
        bus_start();
        put_byte(8'hD2, 1'b1, "R8");
        put_byte(8'h82, 1'b1, "R8");
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        check_ports("R8");
        byte_read(5'd2, "R8");

        // R11 slave released the line at the end
        tick(HP);
        check_val("R11 released", {7'h0, sda_oe}, 8'h00);

        tick(HP);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule